// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single input line. It divides the system clock by a fixed divisor to make a sample tick and takes sixteen ticks per bit. Each bit value comes from a majority vote of three ticks at mid-bit. A character has one start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. When a character completes, the block stores it and raises a ready flag. Noise, framing and parity flags are raised in the same cycle as the ready flag.

A host reaches the block through a small register bus: a two-bit address, read and write strobes, write data and combinational read data. The error flags clear only through a fixed sequence. The host first reads the status register while the flag is set, and then reads the data register.

A separate break monitor counts how long the line stays low. It normally trips after 10 bit times. In the long-break mode it trips after 11 bit times, and framed characters whose stop bit is low are dropped instead of being reported. The break flag is cleared by writing one to it.

Top module: `uartrx_lin`

## Requirements
- R1: After reset, the status register (address 0), the break register (address 1), the data register (address 2) and the control register (address 3) all read as 0.
- R2: A start bit is followed by 8 data bits, least significant bit first. Each bit is taken as the majority of samples 7, 8 and 9 out of 16. The character then appears at address 2, and ready (address 0, bit 3) is set. Reading address 2 clears ready.
- R3: A start bit whose mid-bit majority is high is dropped. No flag changes and the receiver returns to idle.
- R4: If the three mid-bit samples disagree in any bit of the character, including the start and stop bits, the noise flag (address 0, bit 2) is set in the same cycle as ready.
- R5: A low stop-bit majority sets the framing flag (address 0, bit 1) together with ready, but only when long-break mode is off.
- R6: Control bit 0 enables a parity bit after the data bits. Control bit 1 selects odd parity when 1 and even parity when 0. A mismatch sets the parity flag (address 0, bit 0) together with ready. With parity disabled, no parity bit is expected and the parity flag never sets.
- R7: A noise, framing or parity flag clears only when a read of address 0 that saw the flag set is followed by a read of address 2. A read of address 2 alone leaves the flag set.
- R8: With break detection enabled (control bit 2), a low run of 10 bit times sets the break flag (address 1, bit 0). With break detection disabled, the flag stays 0.
- R9: With long-break mode enabled (control bit 3), the break threshold is 11 bit times. A 10.5-bit low run does not set the flag, and an 11.5-bit low run does.
- R10: In long-break mode, a character with a low stop bit raises neither ready nor the framing flag. Characters with a high stop bit are still received normally.
- R11: Writing 1 to bit 0 of address 1 clears the break flag. Writing 0 leaves it unchanged.
- R12: After a character with a low stop bit, the receiver waits for the line to go high before it looks for another start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Serial receive line, idle high |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe; a read has its side effects at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |

## Verification
The assertions check the flag rules on every cycle. An error flag may rise only while ready is set, and a parity flag may rise only if parity was enabled. A framing flag never rises in long-break mode. Ready and the error flags fall only after a data read, and the break flag falls only after a write of one. The bench scenarios cover what depends on timing along the serial line: the majority vote and the noise window, bit order, parity sense, rejection of a false start, the 10 versus 11 bit-time thresholds, and the wait for the line to go high after a low stop bit.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_WAITHI
  } rx_state_e;

  // control register layout, MSB first
  typedef struct packed {
    logic lin_mode;
    logic brk_en;
    logic par_odd;
    logic par_en;
  } ctrl_t;

  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_BRK  = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;
  localparam logic [1:0] ADR_CTRL = 2'd3;

endpackage

// File: rtl/uartrx_tick.sv
module uartrx_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    if (cnt_q == CW'(DIV - 1)) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + CW'(1);
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/uartrx_frame.sv
module uartrx_frame
  import uartrx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          lin_mode,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ne,
  output logic          fe,
  output logic          pe
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned BW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int unsigned MID = OVS / 2;

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d, data_d;
  logic          v_lo_q, v_lo_d, v_mid_q, v_mid_d;
  logic          nz_q, nz_d, pb_q, pb_d;
  logic          done_d, ne_d, fe_d, pe_d;
  logic          vote, split, last, judge;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    v_lo_d  = v_lo_q;
    v_mid_d = v_mid_q;
    nz_d    = nz_q;
    pb_d    = pb_q;
    done_d  = 1'b0;
    data_d  = data;
    ne_d    = ne;
    fe_d    = fe;
    pe_d    = pe;
    vote    = (v_lo_q & v_mid_q) | (v_lo_q & rx) | (v_mid_q & rx);
    split   = ~((v_lo_q == v_mid_q) && (v_mid_q == rx));
    last    = (cnt_q == CW'(OVS - 1));
    judge   = (cnt_q == CW'(MID + 1));
    if (tick) begin
      cnt_d = last ? '0 : cnt_q + CW'(1);
      if (cnt_q == CW'(MID - 1)) v_lo_d = rx;
      if (cnt_q == CW'(MID))     v_mid_d = rx;
      if (judge && st_q != RX_IDLE && st_q != RX_WAITHI) nz_d = nz_q | split;
      case (st_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!rx) begin
            st_d  = RX_START;
            cnt_d = CW'(1);
            nz_d  = 1'b0;
          end
        end
        RX_START: begin
          if (judge && vote) st_d = RX_IDLE;
          else if (last) begin
            st_d  = RX_DATA;
            bit_d = '0;
          end
        end
        RX_DATA: begin
          if (judge) sh_d = {vote, sh_q[DW-1:1]};
          if (last) begin
            if (bit_q == BW'(DW - 1)) st_d = par_en ? RX_PAR : RX_STOP;
            else bit_d = bit_q + BW'(1);
          end
        end
        RX_PAR: begin
          if (judge) pb_d = vote;
          if (last) st_d = RX_STOP;
        end
        RX_STOP: begin
          if (judge) begin
            st_d = vote ? RX_IDLE : RX_WAITHI;
            if (vote || !lin_mode) begin
              done_d = 1'b1;
              data_d = sh_q;
              ne_d   = nz_q | split;
              fe_d   = ~vote;
              pe_d   = par_en & (pb_q ^ (^sh_q) ^ par_odd);
            end
          end
        end
        RX_WAITHI: begin
          if (rx) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      v_lo_q  <= 1'b1;
      v_mid_q <= 1'b1;
      nz_q    <= 1'b0;
      pb_q    <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      ne      <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      v_lo_q  <= v_lo_d;
      v_mid_q <= v_mid_d;
      nz_q    <= nz_d;
      pb_q    <= pb_d;
      done    <= done_d;
      data    <= data_d;
      ne      <= ne_d;
      fe      <= fe_d;
      pe      <= pe_d;
    end
  end
endmodule

// File: rtl/uartrx_brk.sv
module uartrx_brk #(
  parameter int unsigned OVS      = 16,
  parameter int unsigned BRK_BITS = 10,
  parameter int unsigned LIN_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic lin_mode,
  output logic hit
);
  localparam int unsigned NORM_T = OVS * BRK_BITS;
  localparam int unsigned LIN_T  = OVS * LIN_BITS;
  localparam int unsigned MAX_T  = (LIN_T > NORM_T) ? LIN_T : NORM_T;
  localparam int unsigned CW     = $clog2(MAX_T + 1);

  logic [CW-1:0] run_q, run_d, run_inc, thr;
  logic          fired_q, fired_d, hit_d;

  always_comb begin
    run_d   = run_q;
    fired_d = fired_q;
    hit_d   = 1'b0;
    run_inc = run_q + CW'(1);
    thr     = lin_mode ? CW'(LIN_T) : CW'(NORM_T);
    if (tick) begin
      if (rx) begin
        run_d   = '0;
        fired_d = 1'b0;
      end else if (!fired_q) begin
        run_d = run_inc;
        if (run_inc >= thr) begin
          hit_d   = 1'b1;
          fired_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fired_q <= 1'b0;
      hit     <= 1'b0;
    end else begin
      run_q   <= run_d;
      fired_q <= fired_d;
      hit     <= hit_d;
    end
  end
endmodule

// File: rtl/uartrx_lin.sv
module uartrx_lin
  import uartrx_pkg::*;
#(
  parameter int unsigned DIV      = 4,
  parameter int unsigned OVS      = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned BRK_BITS = 10,
  parameter int unsigned LIN_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  logic          rst_meta, rst_ni;
  logic          rx_meta, rx_s;
  logic          tick;
  logic          fr_done, fr_ne, fr_fe, fr_pe;
  logic [DW-1:0] fr_data;
  logic          brk_hit;

  ctrl_t         ctrl_q, ctrl_d;
  logic          rdy_q, rdy_d, brk_q, brk_d;
  logic [2:0]    err_q, err_d, arm_q, arm_d;   // {noise, framing, parity}
  logic [DW-1:0] dat_q, dat_d;
  logic          rd_stat, rd_data, wr_brk, wr_ctrl;
  logic          unused_wbits;

  assign unused_wbits = ^bus_wdata[7:4];

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_s    <= rx_meta;
    end
  end

  uartrx_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_ni), .tick(tick)
  );

  uartrx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .rx(rx_s),
    .par_en(ctrl_q.par_en), .par_odd(ctrl_q.par_odd), .lin_mode(ctrl_q.lin_mode),
    .done(fr_done), .data(fr_data), .ne(fr_ne), .fe(fr_fe), .pe(fr_pe)
  );

  uartrx_brk #(.OVS(OVS), .BRK_BITS(BRK_BITS), .LIN_BITS(LIN_BITS)) u_brk (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .rx(rx_s),
    .lin_mode(ctrl_q.lin_mode), .hit(brk_hit)
  );

  always_comb begin
    rd_stat = bus_rd && (bus_addr == ADR_STAT);
    rd_data = bus_rd && (bus_addr == ADR_DATA);
    wr_brk  = bus_wr && (bus_addr == ADR_BRK);
    wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);

    ctrl_d = wr_ctrl ? ctrl_t'(bus_wdata[3:0]) : ctrl_q;
    rdy_d  = rdy_q;
    err_d  = err_q;
    arm_d  = arm_q;
    dat_d  = dat_q;
    brk_d  = brk_q;

    if (rd_stat) arm_d = err_q;
    if (rd_data) begin
      err_d = err_q & ~arm_q;
      arm_d = '0;
      rdy_d = 1'b0;
    end
    if (fr_done) begin
      rdy_d = 1'b1;
      dat_d = fr_data;
      err_d = err_d | {fr_ne, fr_fe, fr_pe};
    end
    if (wr_brk && bus_wdata[0]) brk_d = 1'b0;
    if (brk_hit && ctrl_q.brk_en) brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rdy_q  <= 1'b0;
      err_q  <= '0;
      arm_q  <= '0;
      dat_q  <= '0;
      brk_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rdy_q  <= rdy_d;
      err_q  <= err_d;
      arm_q  <= arm_d;
      dat_q  <= dat_d;
      brk_q  <= brk_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_STAT: bus_rdata = {4'b0, rdy_q, err_q};
      ADR_BRK:  bus_rdata = {7'b0, brk_q};
      ADR_DATA: bus_rdata = 8'(dat_q);
      default:  bus_rdata = {4'b0, ctrl_q};
    endcase
  end
endmodule

// File: rtl/uartrx_chk.sv
module uartrx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy,
  input logic [2:0] err,
  input logic       brk,
  input logic [3:0] ctrl,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       wbit0
);
  a_r4_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err[0]) || $rose(err[1]) || $rose(err[2])) |-> rdy)
    else $error("a_r4_err_with_ready");

  a_r6_parity_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[0]) |-> $past(ctrl[0], 2))
    else $error("a_r6_parity_needs_enable");

  a_r10_no_frame_err_in_lin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[1]) |-> !$past(ctrl[3], 2))
    else $error("a_r10_no_frame_err_in_lin");

  a_r7_err_clear_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err) & ~err)) |-> $past(bus_rd && bus_addr == 2'd2))
    else $error("a_r7_err_clear_on_data_read");

  a_r2_ready_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(bus_rd && bus_addr == 2'd2))
    else $error("a_r2_ready_clear_on_read");

  a_r8_break_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> $past(ctrl[2]))
    else $error("a_r8_break_needs_enable");

  a_r11_break_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk) |-> $past(bus_wr && bus_addr == 2'd1 && wbit0))
    else $error("a_r11_break_w1c");
endmodule

bind uartrx_lin uartrx_chk u_chk (
  .clk(clk), .rst_n(rst_ni), .rdy(rdy_q), .err(err_q), .brk(brk_q),
  .ctrl(ctrl_q), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .wbit0(bus_wdata[0])
);

// File: tb/tb_uartrx_lin.sv
module tb_uartrx_lin;
  localparam int DIV = 4;
  localparam int BT  = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n, rx, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  int         checks = 0, errs = 0;
  logic [10:0] expq[$];   // {noise, framing, parity, data}

  always #10 clk = ~clk;

  uartrx_lin #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .bus_addr(addr), .bus_rd(rd),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic hold(input logic v, input int clocks);
    for (int c = 0; c < clocks; c++) begin @(negedge clk); rx = v; end
  endtask

  // pmode 0 none, 1 even, 2 odd; nidx is the bit index (start = 0) that gets one flipped mid sample
  task automatic send_frame(input logic [7:0] d, input int pmode, input bit badpar,
                            input logic stopv, input int nidx, input bit lin, input int tail_low);
    logic [11:0] bits;
    int n;
    logic p;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    n = 9;
    p = (pmode == 2) ? ~^d : ^d;
    if (pmode != 0) begin bits[n] = p ^ badpar; n++; end
    bits[n] = stopv; n++;
    if (stopv || !lin)
      expq.push_back({nidx >= 0, ~stopv, (pmode != 0) && badpar, d});
    for (int i = 0; i < n; i++)
      for (int c = 0; c < BT; c++) begin
        @(negedge clk);
        rx = (i == nidx && c >= 8*DIV && c < 9*DIV) ? ~bits[i] : bits[i];
      end
    if (tail_low > 0) hold(1'b0, tail_low);
    hold(1'b1, 2*BT);
  endtask

  task automatic monitor(input int n);
    int got = 0, tmo = 0;
    logic [7:0] s, d;
    logic [10:0] e;
    while (got < n && tmo < 40000) begin
      bus_read(2'd0, s);
      if (s[3]) begin
        e = expq.pop_front();
        chk("R4 noise flag", s[2], e[10]);
        chk("R5 framing flag", s[1], e[9]);
        chk("R6 parity flag", s[0], e[8]);
        bus_read(2'd2, d);
        chk("R2 received data", d, e[7:0]);
        got++;
      end
      tmo++;
    end
    chk("R2 characters received", got, n);
    bus_read(2'd0, s);
    chk("R7 flags cleared by status+data read", s, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rx = 1'b1; rd = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'd0; rst_n = 1'b0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), v);
      chk("R1 reset value", v, 0);
    end

    // R2 plain characters, parity off
    fork
      begin
        send_frame(8'hA5, 0, 0, 1, -1, 0, 0);
        send_frame(8'h3C, 0, 0, 1, -1, 0, 0);
        send_frame(8'hFF, 0, 0, 1, -1, 0, 0);
        send_frame(8'h00, 0, 0, 1, -1, 0, 0);
      end
      monitor(4);
    join

    // R4 noise in a data bit and in the stop bit
    fork
      begin
        send_frame(8'h5A, 0, 0, 1, 4, 0, 0);
        send_frame(8'h81, 0, 0, 1, 9, 0, 0);
      end
      monitor(2);
    join

    // R6 even parity
    bus_write(2'd3, 8'h01);
    fork
      begin
        send_frame(8'h96, 1, 0, 1, -1, 0, 0);
        send_frame(8'h11, 1, 1, 1, -1, 0, 0);
      end
      monitor(2);
    join
    // R6 odd parity
    bus_write(2'd3, 8'h03);
    fork
      begin
        send_frame(8'h07, 2, 0, 1, -1, 0, 0);
        send_frame(8'h07, 2, 1, 1, -1, 0, 0);
      end
      monitor(2);
    join

    // R5 framing error, R12 line held low after stop must not restart
    bus_write(2'd3, 8'h00);
    fork
      begin
        send_frame(8'h81, 0, 0, 0, -1, 0, 2*BT);
        send_frame(8'h42, 0, 0, 1, -1, 0, 0);
      end
      monitor(2);
    join
    chk("R12 no extra character queued", expq.size(), 0);

    // R3 short low pulse is not a start bit
    hold(1'b0, 3*DIV);
    hold(1'b1, 12*BT);
    bus_read(2'd0, v);
    chk("R3 false start sets nothing", v, 0);
    fork
      send_frame(8'hC3, 0, 0, 1, -1, 0, 0);
      monitor(1);
    join

    // R7 data read alone keeps the flag; status then data clears it
    bus_write(2'd3, 8'h01);
    send_frame(8'h11, 1, 1, 1, -1, 0, 0);
    void'(expq.pop_front());
    bus_read(2'd2, v);
    chk("R7 data value", v, 8'h11);
    bus_read(2'd0, v);
    chk("R7 parity kept after bare data read", v, 8'h01);
    bus_read(2'd2, v);
    bus_read(2'd0, v);
    chk("R7 parity cleared after sequence", v, 0);

    // R8 break detection disabled
    bus_write(2'd3, 8'h00);
    hold(1'b0, 21*BT/2);
    hold(1'b1, 3*BT);
    bus_read(2'd1, v);
    chk("R8 no break flag when disabled", v, 0);
    bus_read(2'd0, v);
    chk("R5 break character framing", v, 8'h0A);
    bus_read(2'd2, v);
    chk("R5 break character data", v, 0);

    // R8 enabled, 10-bit threshold
    bus_write(2'd3, 8'h04);
    hold(1'b0, 21*BT/2);
    hold(1'b1, 3*BT);
    bus_read(2'd1, v);
    chk("R8 break flag set", v, 1);
    bus_read(2'd0, v);
    chk("R5 framing with break", v, 8'h0A);
    bus_read(2'd2, v);
    // R11 write-one-to-clear
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v);
    chk("R11 write 0 keeps flag", v, 1);
    bus_write(2'd1, 8'h01);
    bus_read(2'd1, v);
    chk("R11 write 1 clears flag", v, 0);

    // R9/R10 long-break mode
    bus_write(2'd3, 8'h0C);
    hold(1'b0, 21*BT/2);
    hold(1'b1, 3*BT);
    bus_read(2'd1, v);
    chk("R9 10.5-bit low below threshold", v, 0);
    bus_read(2'd0, v);
    chk("R10 no ready or framing", v, 0);
    hold(1'b0, 23*BT/2);
    hold(1'b1, 3*BT);
    bus_read(2'd1, v);
    chk("R9 11.5-bit low reaches threshold", v, 1);
    bus_read(2'd0, v);
    chk("R10 no ready or framing after break", v, 0);
    bus_write(2'd1, 8'h01);
    fork
      send_frame(8'h55, 0, 0, 1, -1, 1, 0);
      monitor(1);
    join
    bus_read(2'd1, v);
    chk("R10 normal character sets no break", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule